// File: doc/BRIEF.md
# Shared-Rate Multi-Channel PWM Generator

This block drives a set of pulse-width modulated lines that all run at one common base rate. A configuration write delivers a frequency code. Code 0 selects the 16 kHz default. Each higher code halves the rate, so code 7 runs at 125 Hz. A write that carries a code above 7 is refused: the error flag goes up and the running rate stays as it was.

Each channel has its own duty word and its own resolution flag. In fine mode the full duty word, 10 bits by default, is compared against a 10-bit period counter. In coarse mode only the low 8 bits count. They are scaled up by the width difference so that they span the same full-scale range. A duty of zero holds the line low. An all-ones duty in the selected mode holds the line high for the whole period.

A new code or duty word is sampled only at a period boundary. Every pulse that is started therefore runs to completion. A prescaler divides the system clock, whose frequency is a parameter, down to the counter step rate of the base frequency.

Top module: `pwm_freqsel`

## Requirements
- R1: After reset every PWM line is low, the error flag is low and the active frequency code is 0.
- R2: With active code c, one PWM period lasts (2^FINE_W) * BASE_DIV * 2^c system clock cycles. BASE_DIV is SYS_CLK_HZ / (16000 * 2^FINE_W), and it is at least 1.
- R3: In fine mode (the mode flag is 1), a channel is high for the first duty * BASE_DIV * 2^c cycles of each period and low for the rest.
- R4: In coarse mode (the mode flag is 0), only duty bits [COARSE_W-1:0] are used. Their value is shifted left by FINE_W-COARSE_W to form the effective duty.
- R5: A duty value of zero holds the line low for the whole period.
- R6: A duty value that is all ones in the active mode's width holds the line high for the whole period.
- R7: A configuration write whose code is 8 to 15 on the 4-bit code input sets the error flag and does not change the pending or active frequency.
- R8: A write with a legal code (0 to 7) clears the error flag. Without a write, the error flag keeps its value.
- R9: A frequency change takes effect on all channels at the same period boundary.
- R10: A new code or duty value takes effect only at the next period boundary. A period that is already running keeps its length and its high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the frequency code |
| cfg_code | input | 4 | Frequency code; 0 to 7 are legal |
| duty_i | input | N*FINE_W | Per-channel duty words, channel k at bits [k*FINE_W +: FINE_W] |
| fine_i | input | N | Per-channel resolution flag: 1 for fine, 0 for coarse |
| pwm_o | output | N | PWM output lines |
| cfg_err | output | 1 | Set by an illegal code write, cleared by a legal one |

## Verification
The period and the high time are measured from one rising edge to the next under several patterns. Directed fine and coarse values use the same raw number, which shows whether the coarse scaling is applied. Zero and all-ones duty words show whether the ends of the range are clamped or merely compared. A duty change and a code change are each written in the middle of a running period: an unchanged length or high time in that period, followed by the new values in the next one, separates boundary-aligned loading from immediate loading. Random trials over codes, channels, modes and duty values then check the rate scaling together with the compare, and illegal codes are interleaved with legal ones to exercise the error flag.

// File: rtl/pwmfs_pkg.sv
package pwmfs_pkg;

    localparam int CODE_IN_W = 4;
    localparam int CODE_W    = 3;
    localparam int CODE_MAX  = 7;
    localparam int BASE_HZ   = 16000;

    typedef logic [CODE_W-1:0] freq_code_t;

    typedef enum logic {
        MODE_COARSE = 1'b0,
        MODE_FINE   = 1'b1
    } res_mode_e;

    function automatic logic code_ok(input logic [CODE_IN_W-1:0] c);
        return c <= CODE_IN_W'(CODE_MAX);
    endfunction

endpackage

// File: rtl/pwmfs_prescaler.sv
module pwmfs_prescaler
    import pwmfs_pkg::*;
#(
    parameter int BASE_DIV = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  freq_code_t code,
    output logic       tick
);
    localparam int PRE_W = $clog2(BASE_DIV * (1 << CODE_MAX)) + 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit_m1;

    always_comb begin
        limit_m1 = (PRE_W'(BASE_DIV) << code) - PRE_W'(1);
        tick     = (pre_q == limit_m1);
    end

    always_ff @(posedge clk) begin
        if (rst)       pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + PRE_W'(1);
    end
endmodule

// File: rtl/pwmfs_period.sv
module pwmfs_period #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    assign wrap = tick && (&cnt);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/pwmfs_channel.sv
module pwmfs_channel
    import pwmfs_pkg::*;
#(
    parameter int FINE_W   = 10,
    parameter int COARSE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap,
    input  logic [FINE_W-1:0] cnt,
    input  logic [FINE_W-1:0] duty_raw,
    input  res_mode_e         mode,
    output logic              pwm
);
    localparam int SHIFT = FINE_W - COARSE_W;

    logic [FINE_W:0] duty_q;
    logic [FINE_W:0] duty_eff;
    logic [COARSE_W-1:0] coarse_bits;

    always_comb begin
        coarse_bits = duty_raw[COARSE_W-1:0];
        if (mode == MODE_FINE) begin
            duty_eff = (&duty_raw) ? (FINE_W+1)'(1) << FINE_W
                                   : {1'b0, duty_raw};
        end else begin
            duty_eff = (&coarse_bits) ? (FINE_W+1)'(1) << FINE_W
                                      : {1'b0, coarse_bits, {SHIFT{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       duty_q <= '0;
        else if (wrap) duty_q <= duty_eff;
    end

    assign pwm = ({1'b0, cnt} < duty_q);
endmodule

// File: rtl/pwm_freqsel.sv
module pwm_freqsel
    import pwmfs_pkg::*;
#(
    parameter int N          = 4,
    parameter int FINE_W     = 10,
    parameter int COARSE_W   = 8,
    parameter int SYS_CLK_HZ = 50_000_000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wr,
    input  logic [CODE_IN_W-1:0]  cfg_code,
    input  logic [N*FINE_W-1:0]   duty_i,
    input  logic [N-1:0]          fine_i,
    output logic [N-1:0]          pwm_o,
    output logic                  cfg_err
);
    localparam int DIV_RAW  = SYS_CLK_HZ / (BASE_HZ * (1 << FINE_W));
    localparam int BASE_DIV = (DIV_RAW < 1) ? 1 : DIV_RAW;

    freq_code_t        code_pend;
    freq_code_t        code_act;
    logic              tick;
    logic              wrap;
    logic [FINE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_pend <= '0;
            code_act  <= '0;
            cfg_err   <= 1'b0;
        end else begin
            if (cfg_wr) begin
                if (code_ok(cfg_code)) begin
                    code_pend <= cfg_code[CODE_W-1:0];
                    cfg_err   <= 1'b0;
                end else begin
                    cfg_err   <= 1'b1;
                end
            end
            if (wrap) code_act <= code_pend;
        end
    end

    pwmfs_prescaler #(.BASE_DIV(BASE_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .code (code_act),
        .tick (tick)
    );

    pwmfs_period #(.CNT_W(FINE_W)) u_per (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .cnt  (cnt),
        .wrap (wrap)
    );

    for (genvar k = 0; k < N; k++) begin : g_ch
        pwmfs_channel #(.FINE_W(FINE_W), .COARSE_W(COARSE_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .wrap     (wrap),
            .cnt      (cnt),
            .duty_raw (duty_i[k*FINE_W +: FINE_W]),
            .mode     (res_mode_e'(fine_i[k])),
            .pwm      (pwm_o[k])
        );
    end
endmodule

// File: rtl/pwmfs_checker.sv
module pwmfs_checker #(
    parameter int N     = 4,
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr,
    input logic [3:0]       cfg_code,
    input logic             cfg_err,
    input logic [N-1:0]     pwm_o,
    input logic             wrap,
    input logic [2:0]       code_pend,
    input logic [2:0]       code_act,
    input logic [CNT_W-1:0] cnt
);
    a_r7_illegal_sets_err: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_code > 4'd7) |=> cfg_err);

    a_r7_illegal_keeps_code: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_code > 4'd7) |=> $stable(code_pend));

    a_r8_legal_clears_err: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_code <= 4'd7) |=> !cfg_err);

    a_r8_err_holds: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(cfg_err));

    a_r10_code_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(code_act));

    a_r3_rise_at_start: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_o[0]) |-> (cnt == '0));
endmodule

bind pwm_freqsel pwmfs_checker #(.N(N), .CNT_W(FINE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_code  (cfg_code),
    .cfg_err   (cfg_err),
    .pwm_o     (pwm_o),
    .wrap      (wrap),
    .code_pend (code_pend),
    .code_act  (code_act),
    .cnt       (cnt)
);

// File: tb/pwm_freqsel_tb.sv
`timescale 1ns/1ps
module pwm_freqsel_tb;
    localparam int N    = 3;
    localparam int FW   = 6;
    localparam int CW   = 4;
    localparam int SYS  = 2_048_000;
    localparam int DIV  = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [3:0]    cfg_code = '0;
    logic [N*FW-1:0] duty = '0;
    logic [N-1:0]  fine = '0;
    logic [N-1:0]  pwm;
    logic          err;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int cur_code = 0;

    always #10 clk = ~clk;

    pwm_freqsel #(.N(N), .FINE_W(FW), .COARSE_W(CW), .SYS_CLK_HZ(SYS)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_code(cfg_code),
        .duty_i(duty), .fine_i(fine), .pwm_o(pwm), .cfg_err(err)
    );

    function automatic int per_len(int c);
        return (1 << FW) * DIV * (1 << c);
    endfunction

    function automatic int eff_duty(int v, bit f);
        int c;
        if (f) return (v == (1 << FW) - 1) ? (1 << FW) : v;
        c = v % (1 << CW);
        return (c == (1 << CW) - 1) ? (1 << FW) : (c << (FW - CW));
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_duty(int ch, int v, bit f);
        duty[ch*FW +: FW] = FW'(v);
        fine[ch] = f;
    endtask

    task automatic write_code(int c);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_code = 4'(c);
        @(negedge clk);
        cfg_wr = 1'b0;
        if (c <= 7) cur_code = c;
    endtask

    task automatic wait_rise(int ch);
        bit p;
        p = pwm[ch];
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (!p && pwm[ch]) return;
            p = pwm[ch];
        end
    endtask

    task automatic measure(int ch, output int n, output int hi);
        bit p;
        wait_rise(ch);
        n = 1; hi = 1; p = 1'b1;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (!p && pwm[ch]) break;
            p = pwm[ch];
            n++;
            if (pwm[ch]) hi++;
        end
    endtask

    task automatic hold_check(string req, int ch, bit lvl, int cyc);
        int hits;
        hits = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (pwm[ch] == lvl) hits++;
        end
        chk(req, hits, cyc);
    endtask

    initial begin
        int n, hi, c, ch, v, e, old;
        bit f, p0, p2;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pwm low after reset", int'(pwm), 0);
        chk("R1 err low after reset", int'(err), 0);

        set_duty(0, 16, 1'b1);
        set_duty(1, 5, 1'b0);
        set_duty(2, 40, 1'b1);
        measure(0, n, hi);
        chk("R1 R2 default period code 0", n, per_len(0));
        chk("R3 fine high time", hi, 16 * DIV);
        measure(1, n, hi);
        chk("R4 coarse high time", hi, eff_duty(5, 1'b0) * DIV);
        measure(2, n, hi);
        chk("R3 fine high time ch2", hi, 40 * DIV);

        // R10: duty change mid-period leaves the running period alone
        wait_rise(0);
        repeat (10) @(negedge clk);
        set_duty(0, 40, 1'b1);
        repeat (30) @(negedge clk);
        chk("R10 old duty still in force", int'(pwm[0]), 0);
        measure(0, n, hi);
        chk("R10 new duty next period", hi, 40 * DIV);

        // R10 and R9: code change mid-period
        wait_rise(0);
        n = 1; p0 = 1'b1; p2 = pwm[2];
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (n == 5) begin cfg_wr = 1'b1; cfg_code = 4'd1; end
            if (n == 6) cfg_wr = 1'b0;
            if (!p0 && pwm[0]) break;
            p0 = pwm[0]; p2 = pwm[2];
            n++;
        end
        cur_code = 1;
        chk("R10 running period keeps length", n, per_len(0));
        chk("R9 ch2 rises at same boundary", int'(!p2 && pwm[2]), 1);
        measure(0, n, hi);
        chk("R9 ch0 new period", n, per_len(1));
        measure(2, n, hi);
        chk("R9 ch2 new period", n, per_len(1));
        chk("R2 high time scales with code", hi, 40 * DIV * 2);

        // R7 and R8: illegal codes
        write_code(9);
        chk("R7 err set by code 9", int'(err), 1);
        measure(0, n, hi);
        chk("R7 frequency unchanged", n, per_len(1));
        write_code(12);
        chk("R7 err set by code 12", int'(err), 1);
        repeat (7) @(negedge clk);
        chk("R8 err holds without write", int'(err), 1);
        write_code(2);
        chk("R8 legal write clears err", int'(err), 0);
        measure(0, n, hi);
        chk("R2 period code 2", n, per_len(2));

        // R5 and R6: range ends
        old = cur_code;
        write_code(0);
        set_duty(0, 0, 1'b1);
        set_duty(1, 15, 1'b0);
        set_duty(2, 63, 1'b1);
        repeat (per_len(old) + per_len(0) + 4) @(negedge clk);
        hold_check("R5 zero duty low", 0, 1'b0, per_len(0));
        hold_check("R6 coarse full high", 1, 1'b1, per_len(0));
        hold_check("R6 fine full high", 2, 1'b1, per_len(0));
        set_duty(1, 15, 1'b1);
        measure(1, n, hi);
        chk("R4 same value in fine mode not full", hi, 15 * DIV);

        // random trials
        for (int t = 0; t < 14; t++) begin
            old = cur_code;
            c  = int'($urandom % 4);
            ch = int'($urandom % N);
            v  = int'($urandom % (1 << FW));
            f  = 1'($urandom % 2);
            write_code(c);
            set_duty(ch, v, f);
            e = eff_duty(v, f);
            if (e == 0 || e == (1 << FW)) begin
                repeat (per_len(old) + per_len(c) + 4) @(negedge clk);
                hold_check(e == 0 ? "R5 random zero" : "R6 random full",
                           ch, e != 0, per_len(c));
            end else begin
                measure(ch, n, hi);
                chk("R2 random period", n, per_len(c));
                chk(f ? "R3 random fine high" : "R4 random coarse high",
                    hi, e * DIV * (1 << c));
            end
        end

        // slowest code
        write_code(7);
        set_duty(0, 16, 1'b1);
        measure(0, n, hi);
        chk("R2 period code 7", n, per_len(7));
        chk("R3 high time code 7", hi, 16 * DIV * 128);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule